// File: doc/BRIEF.md
# Prioritized Event Frame Arbiter

This block sits in a timing-event generator and decides, on every event-clock cycle, which one of fifteen request sources gets to place its 8-bit event code on the outgoing link. The sources are eight trigger channels, two sequencers, a code arriving from an upstream cascaded generator, a software event register loaded by the host, and three timestamping sources. Each source presents a request and a code. The block picks the winner by a fixed priority, pulses an accept back to it, and registers a 16-bit frame that holds the chosen code and the distributed-bus data byte. A downstream line encoder and serializer consume this frame.

When no source requests, the block sends the idle code 0. Losing sources are not disturbed: they keep their requests raised and compete again on the next cycle. The software source is a register inside the block. A host write loads a code and marks it pending. The pending mark clears once that code has been sent.

Top module: `evt_frame_arbiter`

## Requirements
- R1: While `rst_n` is low at a clock edge, `frame_out` becomes 0, and the software register loses any pending code.
- R2: In a cycle with no pending source, the next frame carries event code 0 in bits [15:8].
- R3: The winner is the highest-ranked pending source. The ranks run from highest to lowest as follows: trigger 0, 1, 2, 3, sequencer 0, sequencer 1, trigger 4, 5, 6, 7, upstream, software, timestamp 0, timestamp 1, timestamp 2.
- R4: In each cycle, at most one accept output is high. It is high only for a requesting source, and only for the winner. A loser gets no accept.
- R5: A software code written by the host stays pending across cycles, however long it keeps losing. It is sent exactly once, after which it is no longer pending.
- R6: `frame_out[15:8]` is the winning code and `frame_out[7:0]` is `dbus_in`, both taken from the same arbitration cycle. The data byte is carried whichever source wins, including when the frame is idle.
- R7: The frame for an arbitration cycle appears on `frame_out` one clock later. The accept pulse is combinational, in the arbitration cycle itself.
- R8: The upstream code is forwarded only when no trigger and no sequencer is requesting.
- R9: A host write (`sw_wr` high) in any cycle makes the written code pending from the next cycle on. If the write lands in the cycle that sends the old software code, the old code is still sent and the new one stays pending. A write while a code is pending but not being sent replaces that code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Event clock |
| rst_n | input | 1 | Synchronous reset, active low |
| trig_req | input | 8 | Trigger requests, bit i is trigger i |
| trig_code | input | 64 | Trigger codes, trigger i at bits [8i+7:8i] |
| seq_req | input | 2 | Sequencer requests |
| seq_code | input | 16 | Sequencer codes, sequencer j at [8j+7:8j] |
| up_req | input | 1 | Upstream generator request |
| up_code | input | 8 | Upstream generator code |
| sw_wr | input | 1 | Host write strobe for the software event register |
| sw_wdata | input | 8 | Software event code to load |
| ts_req | input | 3 | Timestamping requests, bit k is timestamp source k |
| ts_code | input | 24 | Timestamping codes, source k at [8k+7:8k] |
| dbus_in | input | 8 | Distributed-bus byte sampled every cycle |
| trig_ack | output | 8 | Accept pulse per trigger |
| seq_ack | output | 2 | Accept pulse per sequencer |
| up_ack | output | 1 | Accept pulse for the upstream source |
| ts_ack | output | 3 | Accept pulse per timestamping source |
| frame_out | output | 16 | Registered frame {event code, bus byte} |

## Verification
The bench first drives directed patterns. These are each source alone, so every code path is covered; adjacent-rank pairs such as trigger 3 against sequencer 0, sequencer 1 against trigger 4, trigger 7 against upstream, upstream against software, and software against timestamp 0, which expose any slip in the interleaved order; and every source at once. Idle cycles with a changing bus byte separate the idle-code path from a stale code. Software writes are placed in three ways: while the code loses, in the very cycle it is sent, and over a pending code. These pin down the pending-register rules. A long random phase follows, in which sources hold their requests until accepted. It shows that losers are never dropped or accepted twice.

// File: rtl/evtarb_pkg.sv
// Package: shared sizes for the event frame arbiter.
// Assumes a source rank numbering with 0 as the highest priority.
package evtarb_pkg;
    localparam int CODE_W_DEF     = 8;
    localparam int DBUS_W_DEF     = 8;
    localparam int NUM_TRIG_DEF   = 8;
    localparam int TRIG_EARLY_DEF = 4;  // triggers ranked above the sequencers
    localparam int NUM_SEQ_DEF    = 2;
    localparam int NUM_TS_DEF     = 3;
    localparam logic [7:0] IDLE_CODE = 8'h00;

    // Total sources: triggers, sequencers, upstream, software, timestamps.
    function automatic int src_count(input int ntrig, input int nseq, input int nts);
        return ntrig + nseq + 2 + nts;
    endfunction
endpackage

// File: rtl/evt_sw_reg.sv
// Module: software event register. The host loads a code, which stays pending
// until the arbiter accepts it. Assumes the host write strobe is one cycle wide.
module evt_sw_reg #(
    parameter int CODE_W = evtarb_pkg::CODE_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [CODE_W-1:0] wdata,
    input  logic              ack,
    output logic              pend,
    output logic [CODE_W-1:0] code
);
    // Hold pending flag and code; a write takes precedence over an accept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= 1'b0;
            code <= '0;
        end else if (wr) begin
            pend <= 1'b1;
            code <= wdata;
        end else if (ack) begin
            pend <= 1'b0;
        end
    end

    assert_pend_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !ack && !wr) |=> (pend && $stable(code)));
    assert_ack_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !wr) |=> !pend);
    assert_write_loads_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (pend && code == $past(wdata)));
endmodule

// File: rtl/evt_src_map.sv
// Module: maps the named sources onto a rank-ordered request/code vector
// (rank 0 highest) and maps the rank-ordered grant back to per-source accepts.
// Assumes TRIG_EARLY <= NUM_TRIG.
module evt_src_map #(
    parameter int CODE_W     = evtarb_pkg::CODE_W_DEF,
    parameter int NUM_TRIG   = evtarb_pkg::NUM_TRIG_DEF,
    parameter int TRIG_EARLY = evtarb_pkg::TRIG_EARLY_DEF,
    parameter int NUM_SEQ    = evtarb_pkg::NUM_SEQ_DEF,
    parameter int NUM_TS     = evtarb_pkg::NUM_TS_DEF,
    localparam int NSRC      = evtarb_pkg::src_count(NUM_TRIG, NUM_SEQ, NUM_TS)
) (
    input  logic [NUM_TRIG-1:0]        trig_req,
    input  logic [NUM_TRIG*CODE_W-1:0] trig_code,
    input  logic [NUM_SEQ-1:0]         seq_req,
    input  logic [NUM_SEQ*CODE_W-1:0]  seq_code,
    input  logic                       up_req,
    input  logic [CODE_W-1:0]          up_code,
    input  logic                       sw_req,
    input  logic [CODE_W-1:0]          sw_code,
    input  logic [NUM_TS-1:0]          ts_req,
    input  logic [NUM_TS*CODE_W-1:0]   ts_code,
    input  logic [NSRC-1:0]            grant,
    output logic [NSRC-1:0]            rank_req,
    output logic [NSRC*CODE_W-1:0]     rank_code,
    output logic [NUM_TRIG-1:0]        trig_ack,
    output logic [NUM_SEQ-1:0]         seq_ack,
    output logic                       up_ack,
    output logic                       sw_ack,
    output logic [NUM_TS-1:0]          ts_ack
);
    localparam int UP_RANK = NUM_TRIG + NUM_SEQ;
    localparam int SW_RANK = UP_RANK + 1;
    localparam int TS_BASE = SW_RANK + 1;

    // Triggers: the early group precedes the sequencers, the rest follow them.
    for (genvar i = 0; i < NUM_TRIG; i++) begin : g_trig
        localparam int RK = (i < TRIG_EARLY) ? i : i + NUM_SEQ;
        assign rank_req[RK]                       = trig_req[i];
        assign rank_code[RK*CODE_W +: CODE_W]     = trig_code[i*CODE_W +: CODE_W];
        assign trig_ack[i]                        = grant[RK];
    end

    // Sequencers sit right after the early trigger group.
    for (genvar j = 0; j < NUM_SEQ; j++) begin : g_seq
        localparam int RK = TRIG_EARLY + j;
        assign rank_req[RK]                       = seq_req[j];
        assign rank_code[RK*CODE_W +: CODE_W]     = seq_code[j*CODE_W +: CODE_W];
        assign seq_ack[j]                         = grant[RK];
    end

    // Upstream and software occupy the two ranks after all triggers.
    assign rank_req[UP_RANK]                      = up_req;
    assign rank_code[UP_RANK*CODE_W +: CODE_W]    = up_code;
    assign up_ack                                 = grant[UP_RANK];
    assign rank_req[SW_RANK]                      = sw_req;
    assign rank_code[SW_RANK*CODE_W +: CODE_W]    = sw_code;
    assign sw_ack                                 = grant[SW_RANK];

    // Timestamping sources take the lowest ranks.
    for (genvar k = 0; k < NUM_TS; k++) begin : g_ts
        localparam int RK = TS_BASE + k;
        assign rank_req[RK]                       = ts_req[k];
        assign rank_code[RK*CODE_W +: CODE_W]     = ts_code[k*CODE_W +: CODE_W];
        assign ts_ack[k]                          = grant[RK];
    end
endmodule

// File: rtl/evt_prio_pick.sv
// Module: fixed-priority picker. Rank 0 wins over every other rank.
// Produces a one-hot grant and the winner's code (idle code when none).
module evt_prio_pick #(
    parameter int CODE_W = evtarb_pkg::CODE_W_DEF,
    parameter int NSRC   = 15
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NSRC-1:0]    req,
    input  logic [NSRC*CODE_W-1:0] code,
    output logic [NSRC-1:0]    grant,
    output logic               any,
    output logic [CODE_W-1:0]  win_code
);
    logic [NSRC-1:0] higher;  // bit i: some rank above i is requesting

    // Prefix OR chain of requests from the top rank downward.
    assign higher[0] = 1'b0;
    for (genvar i = 1; i < NSRC; i++) begin : g_chain
        assign higher[i] = higher[i-1] | req[i-1];
    end
    assign grant = req & ~higher;
    assign any   = |req;

    // AND-OR mux of the granted code; idle code when no grant.
    always_comb begin
        win_code = CODE_W'(evtarb_pkg::IDLE_CODE);
        for (int i = 0; i < NSRC; i++) begin
            if (grant[i]) win_code = code[i*CODE_W +: CODE_W];
        end
    end

    assert_one_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    assert_grant_needs_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~req) == '0);
    assert_pending_served_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (|req) |-> ($countones(grant) == 1));
endmodule

// File: rtl/evt_frame_arbiter.sv
// Module: top of the event frame arbiter. Gathers all sources, picks one by
// fixed priority, returns a combinational accept, and registers the frame
// {code, bus byte}. Assumes sources hold requests until accepted.
module evt_frame_arbiter #(
    parameter int CODE_W     = evtarb_pkg::CODE_W_DEF,
    parameter int DBUS_W     = evtarb_pkg::DBUS_W_DEF,
    parameter int NUM_TRIG   = evtarb_pkg::NUM_TRIG_DEF,
    parameter int TRIG_EARLY = evtarb_pkg::TRIG_EARLY_DEF,
    parameter int NUM_SEQ    = evtarb_pkg::NUM_SEQ_DEF,
    parameter int NUM_TS     = evtarb_pkg::NUM_TS_DEF
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_TRIG-1:0]         trig_req,
    input  logic [NUM_TRIG*CODE_W-1:0]  trig_code,
    input  logic [NUM_SEQ-1:0]          seq_req,
    input  logic [NUM_SEQ*CODE_W-1:0]   seq_code,
    input  logic                        up_req,
    input  logic [CODE_W-1:0]           up_code,
    input  logic                        sw_wr,
    input  logic [CODE_W-1:0]           sw_wdata,
    input  logic [NUM_TS-1:0]           ts_req,
    input  logic [NUM_TS*CODE_W-1:0]    ts_code,
    input  logic [DBUS_W-1:0]           dbus_in,
    output logic [NUM_TRIG-1:0]         trig_ack,
    output logic [NUM_SEQ-1:0]          seq_ack,
    output logic                        up_ack,
    output logic [NUM_TS-1:0]           ts_ack,
    output logic [CODE_W+DBUS_W-1:0]    frame_out
);
    localparam int NSRC    = evtarb_pkg::src_count(NUM_TRIG, NUM_SEQ, NUM_TS);
    localparam int FRAME_W = CODE_W + DBUS_W;

    logic                   sw_pend, sw_ack;
    logic [CODE_W-1:0]      sw_code;
    logic [NSRC-1:0]        rank_req, grant;
    logic [NSRC*CODE_W-1:0] rank_code;
    logic                   any_req;
    logic [CODE_W-1:0]      win_code;

    evt_sw_reg #(.CODE_W(CODE_W)) i_swreg (
        .clk(clk), .rst_n(rst_n), .wr(sw_wr), .wdata(sw_wdata),
        .ack(sw_ack), .pend(sw_pend), .code(sw_code)
    );

    evt_src_map #(
        .CODE_W(CODE_W), .NUM_TRIG(NUM_TRIG), .TRIG_EARLY(TRIG_EARLY),
        .NUM_SEQ(NUM_SEQ), .NUM_TS(NUM_TS)
    ) i_map (
        .trig_req(trig_req), .trig_code(trig_code),
        .seq_req(seq_req), .seq_code(seq_code),
        .up_req(up_req), .up_code(up_code),
        .sw_req(sw_pend), .sw_code(sw_code),
        .ts_req(ts_req), .ts_code(ts_code),
        .grant(grant), .rank_req(rank_req), .rank_code(rank_code),
        .trig_ack(trig_ack), .seq_ack(seq_ack), .up_ack(up_ack),
        .sw_ack(sw_ack), .ts_ack(ts_ack)
    );

    evt_prio_pick #(.CODE_W(CODE_W), .NSRC(NSRC)) i_pick (
        .clk(clk), .rst_n(rst_n), .req(rank_req), .code(rank_code),
        .grant(grant), .any(any_req), .win_code(win_code)
    );

    // Frame register: winner code in the upper field, bus byte in the lower.
    always_ff @(posedge clk) begin
        if (!rst_n) frame_out <= '0;
        else        frame_out <= {win_code, dbus_in};
    end

    assert_idle_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !any_req |=> (frame_out[FRAME_W-1 -: CODE_W] == '0));
    assert_dbus_carried_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (frame_out[DBUS_W-1:0] == $past(dbus_in)));
    assert_upstream_yields_R8: assert property (@(posedge clk) disable iff (!rst_n)
        up_ack |-> (trig_req == '0 && seq_req == '0));
    assert_sw_yields_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sw_ack |-> (trig_req == '0 && seq_req == '0 && !up_req));
    assert_ts_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ts_ack != '0) |-> (!sw_pend && !up_req && trig_req == '0 && seq_req == '0));
endmodule

// File: tb/test_evt_frame_arbiter.sv
module test_evt_frame_arbiter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  trig_req = '0;
    logic [63:0] trig_code = '0;
    logic [1:0]  seq_req = '0;
    logic [15:0] seq_code = '0;
    logic        up_req = 1'b0;
    logic [7:0]  up_code = '0;
    logic        sw_wr = 1'b0;
    logic [7:0]  sw_wdata = '0;
    logic [2:0]  ts_req = '0;
    logic [23:0] ts_code = '0;
    logic [7:0]  dbus_in = '0;
    logic [7:0]  trig_ack;
    logic [1:0]  seq_ack;
    logic        up_ack;
    logic [2:0]  ts_ack;
    logic [15:0] frame_out;

    int n_cmp = 0, n_bad = 0;
    bit m_sw_pend = 0;
    logic [7:0] m_sw_code = '0;
    logic [15:0] exp_frame = '0;
    int last_win = -1;

    always #5 clk = ~clk;

    evt_frame_arbiter i_evt_frame_arbiter (
        .clk(clk), .rst_n(rst_n), .trig_req(trig_req), .trig_code(trig_code),
        .seq_req(seq_req), .seq_code(seq_code), .up_req(up_req), .up_code(up_code),
        .sw_wr(sw_wr), .sw_wdata(sw_wdata), .ts_req(ts_req), .ts_code(ts_code),
        .dbus_in(dbus_in), .trig_ack(trig_ack), .seq_ack(seq_ack), .up_ack(up_ack),
        .ts_ack(ts_ack), .frame_out(frame_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reference: rank list in priority order, first requester wins.
    task automatic model_pick(output int win, output logic [7:0] code);
        bit r[15];
        logic [7:0] c[15];
        for (int i = 0; i < 4; i++) begin r[i] = trig_req[i]; c[i] = trig_code[8*i +: 8]; end
        for (int j = 0; j < 2; j++) begin r[4+j] = seq_req[j]; c[4+j] = seq_code[8*j +: 8]; end
        for (int i = 4; i < 8; i++) begin r[i+2] = trig_req[i]; c[i+2] = trig_code[8*i +: 8]; end
        r[10] = up_req; c[10] = up_code;
        r[11] = m_sw_pend; c[11] = m_sw_code;
        for (int k = 0; k < 3; k++) begin r[12+k] = ts_req[k]; c[12+k] = ts_code[8*k +: 8]; end
        win = -1; code = 8'h00;
        for (int i = 14; i >= 0; i--) if (r[i]) begin win = i; code = c[i]; end
    endtask

    // One arbitration cycle: inputs already driven after a negedge.
    task automatic tick(input string tag);
        int w;
        logic [7:0] code;
        logic [13:0] exp_ack;
        #1;
        model_pick(w, code);
        exp_ack = '0;
        if (w >= 0 && w < 4)        exp_ack[w] = 1'b1;
        else if (w == 4 || w == 5)  exp_ack[8 + w - 4] = 1'b1;
        else if (w >= 6 && w < 10)  exp_ack[w - 2] = 1'b1;
        else if (w == 10)           exp_ack[10] = 1'b1;
        else if (w >= 12)           exp_ack[11 + w - 12] = 1'b1;
        check({tag, " R3 R4 R8 accept"}, 32'({ts_ack, up_ack, seq_ack, trig_ack}), 32'(exp_ack));
        exp_frame = {code, dbus_in};
        last_win = w;
        @(posedge clk);
        if (sw_wr) begin m_sw_pend = 1; m_sw_code = sw_wdata; end
        else if (w == 11) m_sw_pend = 0;
        @(negedge clk);
        check({tag, " R6 R7 frame"}, 32'(frame_out), 32'(exp_frame));
        if (w < 0) check({tag, " R2 idle"}, 32'(frame_out[15:8]), 32'h0);
    endtask

    task automatic clear_in();
        trig_req = '0; seq_req = '0; up_req = 0; ts_req = '0; sw_wr = 0;
    endtask

    initial begin
        #2000000;
        n_bad++; n_cmp++;
        $display("FAIL watchdog R1 actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) trig_code[8*i +: 8] = 8'h10 + 8'(i);
        seq_code = 16'h2221; up_code = 8'h30; ts_code = 24'h434241;
        // Reset: hold requests high, expect a clear frame.
        trig_req = 8'hFF; dbus_in = 8'h5A; sw_wr = 1; sw_wdata = 8'h77;
        repeat (3) @(negedge clk);
        check("R1 reset frame", 32'(frame_out), 32'h0);
        clear_in(); rst_n = 1;
        @(negedge clk);
        check("R1 reset frame held idle", 32'(frame_out[15:8]), 32'h0);
        // Idle with changing bus byte (R2, R6).
        dbus_in = 8'hA5; tick("idle1");
        dbus_in = 8'h3C; tick("idle2");
        // Each source alone.
        for (int i = 0; i < 8; i++) begin clear_in(); trig_req[i] = 1; dbus_in = 8'(i); tick("trig alone"); end
        for (int j = 0; j < 2; j++) begin clear_in(); seq_req[j] = 1; tick("seq alone"); end
        clear_in(); up_req = 1; tick("up alone");
        for (int k = 0; k < 3; k++) begin clear_in(); ts_req[k] = 1; tick("ts alone"); end
        clear_in(); sw_wr = 1; sw_wdata = 8'h5E; tick("sw write R9");
        clear_in(); tick("sw sent alone R5");
        clear_in(); tick("sw gone R5");
        // Adjacent rank pairs.
        clear_in(); trig_req[3] = 1; seq_req[0] = 1; tick("trig3 vs seq0");
        clear_in(); seq_req[1] = 1; trig_req[4] = 1; tick("seq1 vs trig4");
        clear_in(); trig_req[7] = 1; up_req = 1; tick("trig7 vs up R8");
        clear_in(); seq_req[1] = 1; up_req = 1; tick("seq vs up R8");
        // Software pending while losing, then sent (R5).
        clear_in(); sw_wr = 1; sw_wdata = 8'h66; tick("sw load");
        clear_in(); up_req = 1; tick("up vs sw");
        clear_in(); up_req = 1; tick("up vs sw again R5");
        clear_in(); ts_req[0] = 1; tick("sw vs ts0 R5");
        // Write over a pending code (R9).
        clear_in(); up_req = 1; sw_wr = 1; sw_wdata = 8'h67; tick("sw load2");
        clear_in(); up_req = 1; sw_wr = 1; sw_wdata = 8'h68; tick("sw replace R9");
        // Write in the sending cycle (R9).
        clear_in(); sw_wr = 1; sw_wdata = 8'h69; tick("sw send+write R9");
        clear_in(); tick("sw new sent R9");
        clear_in(); tick("sw empty R5");
        clear_in(); ts_req = 3'b110; tick("ts1 vs ts2");
        // All at once.
        clear_in(); trig_req = 8'hFF; seq_req = 2'b11; up_req = 1; ts_req = 3'b111;
        sw_wr = 1; sw_wdata = 8'h70; tick("all");
        // Random phase: sources hold requests until accepted.
        clear_in();
        for (int n = 0; n < 3000; n++) begin
            if (last_win >= 0 && last_win < 4) trig_req[last_win] = 0;
            else if (last_win == 4 || last_win == 5) seq_req[last_win-4] = 0;
            else if (last_win >= 6 && last_win < 10) trig_req[last_win-2] = 0;
            else if (last_win == 10) up_req = 0;
            else if (last_win >= 12) ts_req[last_win-12] = 0;
            for (int i = 0; i < 8; i++)
                if (!trig_req[i] && ($urandom % 8 == 0)) begin trig_req[i] = 1; trig_code[8*i +: 8] = 8'($urandom); end
            for (int j = 0; j < 2; j++)
                if (!seq_req[j] && ($urandom % 8 == 0)) begin seq_req[j] = 1; seq_code[8*j +: 8] = 8'($urandom); end
            if (!up_req && ($urandom % 8 == 0)) begin up_req = 1; up_code = 8'($urandom); end
            for (int k = 0; k < 3; k++)
                if (!ts_req[k] && ($urandom % 10 == 0)) begin ts_req[k] = 1; ts_code[8*k +: 8] = 8'($urandom); end
            sw_wr = ($urandom % 12 == 0); sw_wdata = 8'($urandom);
            dbus_in = 8'($urandom);
            tick("random");
        end
        // Reset mid-run with a pending software code (R1).
        clear_in(); sw_wr = 1; sw_wdata = 8'h99; up_req = 1; tick("pre-reset load");
        clear_in(); rst_n = 0; @(negedge clk); rst_n = 1; m_sw_pend = 0;
        check("R1 frame after reset", 32'(frame_out), 32'h0);
        tick("R1 sw cleared by reset");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule